// File: doc/BRIEF.md
# Bidirectional Common Scan Register

This block steps a scan token along the common (row) electrodes of a dot-matrix LCD. A serial bit enters at one end of a 64-stage register on each active edge of a shift clock. It moves one stage per edge. For every stage the block gives a 2-bit drive-level code. The code combines the stage bit with the frame-inversion signal and names one of four LCD bias levels. The analog switches and voltage rails are outside the block; it only encodes which level each row must take.

Two straps set the block's behaviour. One picks the shift direction, and with it which end pin takes data in and which end pin carries the last stage out. The other picks whether the rising or the falling edge of the shift clock is active. The output-side end pin feeds the next device in a cascade, so two blocks can scan up to 128 rows. In master mode both end pins drive out. The token then comes from the timing-generator input, not from a pin.

The shift clock is treated as a level that is synchronous to the system clock `clk`. An edge is seen when its sampled value changes between two `clk` edges, and the register moves on that same `clk` edge.

Top module: `com_scan_driver`

## Requirements
- R1: With `dir_fwd`=1, each active edge moves stage i to stage i+1, and the serial input enters stage 0 (the row-1 end, code bits [1:0]).
- R2: With `dir_fwd`=0, each active edge moves stage i to stage i-1, and the serial input enters stage 63 (code bits [127:126]).
- R3: In slave mode (`master`=0), `dir_fwd`=1 makes the left pin the input (`left_oe`=0) and the right pin an output (`right_oe`=1). `dir_fwd`=0 swaps the two roles. The pin that is not the input is ignored.
- R4: With `rise_sel`=1 only a 0-to-1 change of `cl_shift` shifts. With `rise_sel`=0 only a 1-to-0 change shifts. With no active edge the stages hold.
- R5: The output-side pin always carries the last stage in the shift direction: stage 63 on `right_out` when forward, stage 0 on `left_out` when reverse.
- R6: The drive code of row i is {stage bit, `frame_m`}: 2'b11 selects V2, 2'b01 selects V6, 2'b10 selects V1 and 2'b00 selects V5. V1 and V2 are the selected levels.
- R7: Reset clears every stage, so every row selects a non-selected level: V5 (00) when `frame_m`=0, V6 (01) when `frame_m`=1. After reset the shift clock is taken to be low.
- R8: In master mode both end pins are outputs. The serial input is `token_gen`, and the input-side pin echoes `token_gen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_shift | input | 1 | Shift clock level, synchronous to clk |
| rise_sel | input | 1 | Edge strap: 1 rising, 0 falling |
| dir_fwd | input | 1 | Direction strap: 1 left to right, 0 right to left |
| master | input | 1 | 1 master, 0 slave |
| token_gen | input | 1 | Token from the timing generator (master mode) |
| frame_m | input | 1 | Frame-inversion signal |
| left_in | input | 1 | Left end pin, input value |
| left_out | output | 1 | Left end pin, output value |
| left_oe | output | 1 | Left end pin drive enable |
| right_in | input | 1 | Right end pin, input value |
| right_out | output | 1 | Right end pin, output value |
| right_oe | output | 1 | Right end pin drive enable |
| drive_lvl | output | 128 | Two code bits per row, row i at [2i+1:2i] |

## Verification
A single token is walked across all 64 stages in each direction. This shows whether the shift order is right and whether the end pin echoes the correct stage. Runs in falling-edge mode apply rising edges that must do nothing, which separates the edge strap from plain toggle counting. Random mixes of direction, edge strap, mode, serial bits, idle pin values and `frame_m` are compared row by row with a bench model. These expose a wrong input-pin choice, a wrong code bit order, or a change on the ignored pin that leaks into the register.

// File: rtl/com_scan_driver.sv
module com_scan_driver #(
  parameter int N = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cl_shift,
  input  logic           rise_sel,
  input  logic           dir_fwd,
  input  logic           master,
  input  logic           token_gen,
  input  logic           frame_m,
  input  logic           left_in,
  output logic           left_out,
  output logic           left_oe,
  input  logic           right_in,
  output logic           right_out,
  output logic           right_oe,
  output logic [2*N-1:0] drive_lvl
);

  logic [N-1:0] stage;
  logic         sc_q;

  wire ser_in   = master ? token_gen : (dir_fwd ? left_in : right_in);
  wire edge_hit = rise_sel ? (cl_shift & ~sc_q) : (~cl_shift & sc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      sc_q  <= 1'b0;
    end else begin
      sc_q <= cl_shift;
      if (edge_hit)
        stage <= dir_fwd ? {stage[N-2:0], ser_in} : {ser_in, stage[N-1:1]};
    end
  end

  assign left_oe   = master | ~dir_fwd;
  assign right_oe  = master | dir_fwd;
  assign left_out  = dir_fwd ? token_gen : stage[0];
  assign right_out = dir_fwd ? stage[N-1] : token_gen;

  for (genvar i = 0; i < N; i++) begin : g_row
    assign drive_lvl[2*i+1:2*i] = {stage[i], frame_m};
  end

endmodule

// File: rtl/com_scan_driver_chk.sv
module com_scan_driver_chk #(
  parameter int N = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cl_shift,
  input logic           rise_sel,
  input logic           dir_fwd,
  input logic           master,
  input logic           token_gen,
  input logic           frame_m,
  input logic           left_in,
  input logic           left_out,
  input logic           left_oe,
  input logic           right_in,
  input logic           right_out,
  input logic           right_oe,
  input logic [2*N-1:0] drive_lvl
);

  logic [N-1:0] bits;
  logic [N-1:0] mbits;
  for (genvar i = 0; i < N; i++) begin : g_x
    assign bits[i]  = drive_lvl[2*i+1];
    assign mbits[i] = drive_lvl[2*i];
  end

  logic sc_d, seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_d <= 1'b0;
      seen <= 1'b0;
    end else begin
      sc_d <= cl_shift;
      seen <= 1'b1;
    end
  end

  wire fire = seen && (rise_sel ? (cl_shift && !sc_d) : (!cl_shift && sc_d));
  wire idle = seen && (cl_shift == sc_d);
  wire sin  = master ? token_gen : (dir_fwd ? left_in : right_in);

  a_r1_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dir_fwd) |=> (bits == {$past(bits[N-2:0]), $past(sin)}));

  a_r2_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dir_fwd) |=> (bits == {$past(sin), $past(bits[N-1:1])}));

  a_r3_slave_roles: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (left_oe == !dir_fwd) && (right_oe == dir_fwd));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(bits));

  a_r5_echo_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |-> (right_out == bits[N-1]));

  a_r5_echo_rev: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |-> (left_out == bits[0]));

  a_r6_m_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mbits == {N{frame_m}}));

  a_r8_master_oe: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> (left_oe && right_oe));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clear: assert (bits == '0);
    end
  end

endmodule

bind com_scan_driver com_scan_driver_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cl_shift(cl_shift), .rise_sel(rise_sel),
  .dir_fwd(dir_fwd), .master(master), .token_gen(token_gen),
  .frame_m(frame_m), .left_in(left_in), .left_out(left_out),
  .left_oe(left_oe), .right_in(right_in), .right_out(right_out),
  .right_oe(right_oe), .drive_lvl(drive_lvl)
);

// File: tb/com_scan_driver_tb.sv
module com_scan_driver_tb;
  localparam int N = 64;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cl_shift = 0, rise_sel = 1, dir_fwd = 1, master = 0, token_gen = 0;
  logic frame_m = 0, left_in = 0, right_in = 0;
  logic left_out, left_oe, right_out, right_oe;
  logic [2*N-1:0] drive_lvl;

  com_scan_driver #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cl_shift(cl_shift), .rise_sel(rise_sel),
    .dir_fwd(dir_fwd), .master(master), .token_gen(token_gen),
    .frame_m(frame_m), .left_in(left_in), .left_out(left_out),
    .left_oe(left_oe), .right_in(right_in), .right_out(right_out),
    .right_oe(right_oe), .drive_lvl(drive_lvl)
  );

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] model = '0;

  function automatic logic [2*N-1:0] exp_lvl(logic [N-1:0] s, logic m);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i+1 -: 2] = {s[i], m};
    return r;
  endfunction

  task automatic chk(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, drive_lvl, exp_lvl(model, frame_m));
    if (dir_fwd) chk({req, " R5 right echo"}, {127'b0, right_out}, {127'b0, model[N-1]});
    else         chk({req, " R5 left echo"},  {127'b0, left_out},  {127'b0, model[0]});
  endtask

  // drive a step at negedge, model it, check at the following negedge
  task automatic step(logic sc, logic lin, logic rin, logic tg);
    logic act, sin;
    @(negedge clk);
    act = rise_sel ? (sc && !cl_shift) : (!sc && cl_shift);
    sin = master ? tg : (dir_fwd ? lin : rin);
    cl_shift = sc; left_in = lin; right_in = rin; token_gen = tg;
    if (act) model = dir_fwd ? {model[N-2:0], sin} : {sin, model[N-1:1]};
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R7 reset m=0", drive_lvl, {N{2'b00}});
    frame_m = 1; #1;
    chk("R7 reset m=1", drive_lvl, {N{2'b01}});
    rst_n = 1;
    @(negedge clk);
    chk("R7 after release", drive_lvl, {N{2'b01}});

    // R3 roles in slave mode
    chk("R3 fwd oe", {126'b0, left_oe, right_oe}, {126'b0, 2'b01});
    dir_fwd = 0; #1;
    chk("R3 rev oe", {126'b0, left_oe, right_oe}, {126'b0, 2'b10});
    dir_fwd = 1;

    // R1: walk one token forward on rising edges, right pin toggling (ignored)
    step(1, 1, 1, 0); step(0, 0, 0, 0);
    chk_state("R1 token at row1");
    chk("R6 row1 is V2", {126'b0, drive_lvl[1:0]}, {126'b0, 2'b11});
    for (int k = 1; k < N; k++) begin
      step(1, 0, k[0], 0); step(0, 0, 0, 0);
      if (k % 8 == 0 || k == N-1) chk_state("R1 walk fwd");
    end
    chk("R5 token at last stage", {127'b0, right_out}, {127'b0, 1'b1});
    step(1, 0, 0, 0); step(0, 0, 0, 0);
    chk_state("R1 token shifted out");

    // R2: reverse walk, left pin ignored
    dir_fwd = 0;
    step(1, 1, 1, 0); step(0, 1, 0, 0);
    chk_state("R2 token at row64");
    frame_m = 0; #1;
    chk("R6 row64 is V1", {126'b0, drive_lvl[2*N-1 -: 2]}, {126'b0, 2'b10});
    for (int k = 1; k < N; k++) begin
      step(1, k[0], 0, 0); step(0, 1, 0, 0);
    end
    chk_state("R2 walk rev to row1");

    // R4: falling-edge mode, rising edges must not shift
    dir_fwd = 1; rise_sel = 0;
    step(1, 1, 0, 0);
    chk_state("R4 rising ignored");
    step(0, 1, 0, 0);
    chk_state("R4 falling shifts");
    step(0, 0, 0, 0);
    chk_state("R4 no edge hold");

    // R8: master mode
    master = 1; #1;
    chk("R8 both oe", {126'b0, left_oe, right_oe}, {126'b0, 2'b11});
    step(1, 0, 0, 1); step(0, 0, 0, 1);
    chk_state("R8 token_gen source");
    chk("R8 left echoes gen", {127'b0, left_out}, {127'b0, 1'b1});
    master = 0;

    // random mix
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      dir_fwd = 1'($urandom);
      frame_m = 1'($urandom);
      if ($urandom % 16 == 0) rise_sel = 1'($urandom);
      master = ($urandom % 8 == 0);
      step(($urandom % 3 == 0) ? cl_shift : ~cl_shift,
           1'($urandom), 1'($urandom), 1'($urandom));
      if (it % 50 == 0) chk_state("R1 R2 R4 R6 random");
      else chk("R6 random codes", drive_lvl, exp_lvl(model, frame_m));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule